// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits between a two-wire serial slave and a byte-wide nonvolatile array. The slave decodes the bus. It hands over each received byte as a tagged stream word: high address byte, low address byte or data byte. The controller builds a 16-bit word address from the two address bytes. It then gathers the data bytes of one write transaction in a page-sized buffer. Each buffer entry has its own loaded flag. Data bytes land at the current byte offset, and that offset advances inside the 128-byte page (address bits 6:0). The page index (bits 15:7) never changes during a transaction.

When the slave reports a stop condition, the controller checks whether the transaction carried at least one data byte and whether protection is off. If both hold, it starts a busy window of a fixed number of clock cycles. During the first `PAGE_BYTES` cycles of that window it scans the buffer offsets in ascending order and issues one array write per loaded byte. While busy, `in_ready` is low. The slave uses `in_ready` as its permission to acknowledge any word, the device address included, so a host that polls with a start and a device address sees NACKs until the window closes. The current address is also exposed for the read path, which advances it through `rd_adv`.

Stream rule: a word transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. A word offered while `in_ready` is low is not taken, and the slave is expected to NACK and drop it rather than hold it. The slave never presents a data word and a stop in the same cycle.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `mem_we` is 0 and `cur_addr` is 0.
- R2: An accepted word with `in_kind`=0 holds the address high byte, and an accepted word with `in_kind`=1 sets `cur_addr` to {high byte, low byte}, visible the cycle after the transfer; `in_kind`=3 is discarded.
- R3: An accepted data word (`in_kind`=2) is buffered at offset `cur_addr[6:0]`; then `cur_addr[6:0]` increments modulo 128 while `cur_addr[15:7]` is unchanged.
- R4: When more than 128 data words arrive, the offset wraps within the page and a later byte replaces the earlier one at the same offset; only the latest value reaches the array.
- R5: A stop with `wp`=0 that ends a transaction holding at least one data byte drives `in_ready` low from the next cycle for exactly `WR_CYCLES` cycles.
- R6: During that window `mem_we` pulses once per loaded offset, in ascending offset order, with `mem_addr`={page, offset} and the buffered byte; unloaded offsets are never written, and `mem_we` is 0 whenever `in_ready` is 1.
- R7: While `in_ready` is low, stream words, `ev_stop` and `rd_adv` have no effect: `cur_addr` holds and no further window follows.
- R8: With `wp`=1 at the stop, data words are still accepted but no window starts, nothing is written, and the loaded flags are discarded so a later commit writes only its own bytes.
- R9: A stop ending a transaction with no data byte starts no window and leaves `cur_addr` at the loaded address.
- R10: A `rd_adv` pulse while idle increments the full 16-bit `cur_addr`, wrapping from 0xFFFF to 0.
- R11: After a commit, `cur_addr` holds the address following the last data byte, within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Stream word offered by the serial slave |
| in_ready | output | 1 | Word accepted; also the slave's ACK permission (low while busy) |
| in_kind | input | 2 | 0 address high, 1 address low, 2 data, 3 discarded |
| in_byte | input | 8 | Stream word payload |
| ev_stop | input | 1 | One-cycle pulse: stop condition seen |
| rd_adv | input | 1 | One-cycle pulse: read path consumed a byte |
| wp | input | 1 | Write protect, high inhibits commits |
| cur_addr | output | ADDR_W | Current word address |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with its default 16-bit address and 128-byte page and sets `WR_CYCLES` to 140. With that value every busy window can be counted edge by edge, and a stream of over a hundred bytes runs past the page wrap, while each commit still spends its last cycles idle after the scan. With this short window, many random transactions fit in one run. They mix protected, empty and wrapping writes, together with stray words injected while the block is busy.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    WK_ADDR_HI = 2'd0,
    WK_ADDR_LO = 2'd1,
    WK_DATA    = 2'd2,
    WK_RSVD    = 2'd3
  } wkind_e;
endpackage

// File: rtl/wpc_addr_ctr.sv
module wpc_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [7:0]        byte_in,
  input  logic              step_page,
  input  logic              step_lin,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (ld_hi) begin
      hi_q <= byte_in[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_lo) begin
      addr <= {hi_q, byte_in};
    end else if (step_page) begin
      // offset wraps inside the page, page index untouched
      addr <= {addr[ADDR_W-1:OFF_W], addr[OFF_W-1:0] + OFF_W'(1)};
    end else if (step_lin) begin
      addr <= addr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte,
  input  logic             clr,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte,
  output logic             rd_vld,
  output logic             any_vld
);
  logic [PAGE_BYTES-1:0] vld_q;
  logic [7:0]            store_q [PAGE_BYTES];

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_off == OFF_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
      end else if (hit) begin
        vld_q[i] <= 1'b1;
      end else if (clr) begin
        vld_q[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        store_q[i] <= wr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_vld <= 1'b0;
    end else if (wr_en) begin
      any_vld <= 1'b1;
    end else if (clr) begin
      any_vld <= 1'b0;
    end
  end

  assign rd_byte = store_q[rd_off];
  assign rd_vld  = vld_q[rd_off];
endmodule

// File: rtl/wpc_commit_seq.sv
module wpc_commit_seq #(
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = 7,
  parameter int WR_CYCLES  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic             scan_act,
  output logic [OFF_W-1:0] scan_off,
  output logic             done
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign done     = busy && (cnt_q == CNT_W'(WR_CYCLES - 1));
  assign scan_act = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_off = cnt_q[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (go) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int WR_CYCLES  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [7:0]        in_byte,
  input  logic              ev_stop,
  input  logic              rd_adv,
  input  logic              wp,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  import wpc_pkg::*;

  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  wkind_e            kind;
  logic              busy, take, ld_hi, ld_lo, dat;
  logic              stop_ok, go, clr, done;
  logic              have_data, scan_act, rd_vld;
  logic [OFF_W-1:0]  scan_off;
  logic [7:0]        rd_byte;
  logic [PAGE_W-1:0] page_q;

  assign kind     = wkind_e'(in_kind);
  assign in_ready = !busy;
  assign take     = in_valid && in_ready;
  assign ld_hi    = take && (kind == WK_ADDR_HI);
  assign ld_lo    = take && (kind == WK_ADDR_LO);
  assign dat      = take && (kind == WK_DATA);

  assign stop_ok  = ev_stop && !busy;
  assign go       = stop_ok && have_data && !wp;
  assign clr      = (stop_ok && have_data && wp) || done;

  wpc_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_hi     (ld_hi),
    .ld_lo     (ld_lo),
    .byte_in   (in_byte),
    .step_page (dat),
    .step_lin  (rd_adv && !busy),
    .addr      (cur_addr)
  );

  wpc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat),
    .wr_off  (cur_addr[OFF_W-1:0]),
    .wr_byte (in_byte),
    .clr     (clr),
    .rd_off  (scan_off),
    .rd_byte (rd_byte),
    .rd_vld  (rd_vld),
    .any_vld (have_data)
  );

  wpc_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .busy     (busy),
    .scan_act (scan_act),
    .scan_off (scan_off),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (go) begin
      page_q <= cur_addr[ADDR_W-1:OFF_W];
    end
  end

  assign mem_we    = scan_act && rd_vld;
  assign mem_addr  = {page_q, scan_off};
  assign mem_wdata = rd_byte;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 7,
  parameter int WR_CYCLES = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              ev_stop,
  input logic              wp,
  input logic              have_data,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [31:0]      low_run;
  logic             seen_we;
  logic [OFF_W-1:0] last_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!in_ready) begin
      low_run <= low_run + 32'd1;
    end else begin
      low_run <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_we  <= 1'b0;
      last_off <= '0;
    end else if (in_ready) begin
      seen_we <= 1'b0;
    end else if (mem_we) begin
      seen_we  <= 1'b1;
      last_off <= mem_addr[OFF_W-1:0];
    end
  end

  a_r5_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && in_ready && !wp && have_data |=> !in_ready);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> low_run == 32'(WR_CYCLES));

  a_r6_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_we);

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && seen_we |-> mem_addr[OFF_W-1:0] > last_off);

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(cur_addr));

  a_r8_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && in_ready && wp |=> in_ready);

  a_r9_dummy_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && in_ready && !have_data |=> in_ready);
endmodule

bind page_commit_ctrl page_commit_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_chk (.*);

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
  localparam int CLK_NS = 10;
  localparam int WRC    = 140;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_kind = 2'd0;
  logic [7:0]  in_byte = 8'd0;
  logic        ev_stop = 1'b0;
  logic        rd_adv = 1'b0;
  logic        wp = 1'b0;
  logic [15:0] cur_addr;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0]  exp_val [128];
  logic        exp_vld [128];
  logic [15:0] cap_addr [256];
  logic [7:0]  cap_data [256];
  int          cap_cnt = 0;

  always #(CLK_NS / 2) clk = ~clk;

  page_commit_ctrl #(.ADDR_W(16), .PAGE_BYTES(128), .WR_CYCLES(WRC)) i_page_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_byte(in_byte), .ev_stop(ev_stop), .rd_adv(rd_adv),
    .wp(wp), .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (mem_we && cap_cnt < 256) begin
      cap_addr[cap_cnt] = mem_addr;
      cap_data[cap_cnt] = mem_wdata;
      cap_cnt = cap_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit prot, input bit poke);
    logic [15:0] ea;
    int cnt;
    int k;
    for (int i = 0; i < 128; i++) exp_vld[i] = 1'b0;
    wp = prot;
    send(2'd0, a[15:8]);
    send(2'd1, a[7:0]);
    chk(cur_addr == a, "R2 address load", cur_addr, a);
    ea = a;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_val[ea[6:0]] = b;
      exp_vld[ea[6:0]] = 1'b1;
      if (prot && i == 0) chk(in_ready == 1'b1, "R8 data taken while protected", in_ready, 1);
      send(2'd2, b);
      ea = {ea[15:7], 7'(ea[6:0] + 7'd1)};
      if (i < 3 || i == n - 1) chk(cur_addr == ea, "R3 offset step", cur_addr, ea);
    end
    cap_cnt = 0;
    pulse_stop();
    if (prot || n == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(in_ready == 1'b1, prot ? "R8 no busy when protected" : "R9 no busy on dummy write", in_ready, 1);
        @(negedge clk);
      end
      chk(cap_cnt == 0, prot ? "R8 no array write" : "R9 no array write", cap_cnt, 0);
      chk(cur_addr == ea, "R9 address kept", cur_addr, ea);
    end else begin
      cnt = 0;
      while (!in_ready) begin
        cnt++;
        if (poke && cnt == 10) begin
          in_valid = 1'b1; in_kind = 2'd1; in_byte = 8'h55; rd_adv = 1'b1; ev_stop = 1'b1;
        end else begin
          in_valid = 1'b0; rd_adv = 1'b0; ev_stop = 1'b0;
        end
        @(negedge clk);
        if (poke && cnt == 12) chk(cur_addr == ea, "R7 ignored while busy", cur_addr, ea);
      end
      chk(cnt == WRC, "R5 busy length", cnt, WRC);
      k = 0;
      for (int off = 0; off < 128; off++) begin
        if (exp_vld[off]) begin
          chk(cap_addr[k] == {a[15:7], 7'(off)}, "R6 write address order", cap_addr[k], {a[15:7], 7'(off)});
          chk(cap_data[k] == exp_val[off], n > 128 ? "R4 latest byte wins" : "R6 write data", cap_data[k], exp_val[off]);
          k++;
        end
      end
      chk(cap_cnt == k, "R6 write count", cap_cnt, k);
      chk(cur_addr == ea, "R11 address after commit", cur_addr, ea);
      if (poke) begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(in_ready == 1'b1, "R7 no extra window", in_ready, 1);
        end
      end
    end
    wp = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1729);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
    chk(cur_addr == 16'h0, "R1 address after reset", cur_addr, 0);

    send(2'd3, 8'hAA);
    chk(cur_addr == 16'h0, "R2 reserved kind discarded", cur_addr, 0);

    do_write(16'h1234, 0, 1'b0, 1'b0);
    do_write(16'hFFFF, 0, 1'b0, 1'b0);
    @(negedge clk); rd_adv = 1'b1;
    @(negedge clk); rd_adv = 1'b0;
    chk(cur_addr == 16'h0000, "R10 wrap on advance", cur_addr, 0);
    @(negedge clk); rd_adv = 1'b1;
    @(negedge clk); rd_adv = 1'b0;
    chk(cur_addr == 16'h0001, "R10 advance", cur_addr, 1);

    do_write(16'h0A05, 7, 1'b0, 1'b0);
    do_write(16'h337F, 1, 1'b0, 1'b0);
    do_write(16'h3378, 135, 1'b0, 1'b0);
    do_write(16'h4410, 5, 1'b1, 1'b0);
    do_write(16'h4420, 3, 1'b0, 1'b0);
    do_write(16'h5500, 4, 1'b0, 1'b1);

    for (int t = 0; t < 12; t++) begin
      do_write(16'($urandom), int'($urandom_range(0, 40)), ($urandom % 4) == 0, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule